// File: doc/BRIEF.md
# Serial Transmit Path with Holding Queue

This block is the send half of a classic asynchronous serial port. A host pushes bytes in one at a time. In single-register mode the block holds one byte, and that byte moves into the shifter as soon as the shifter is free. In queued mode a 32-entry first-in first-out buffer sits between the host and the shifter. The shifter sends each character as a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. All bit timing comes from a single-cycle enable pulse that runs at sixteen times the baud rate. The baud generator is outside this block.

The host sees two status flags. `thr_empty` reports that nothing is waiting to be sent. `tx_empty` reports that, in addition, the shifter has finished its last stop bit. A transmit interrupt can be raised when the queue drains: in queued mode it fires when the fill level drops below a programmable trigger level, and again when the queue runs empty. Either a new write or an interrupt-status read clears it.

The write side uses valid/ready signalling with one rule that differs from a stalling stream. `wr_ready` shows whether there is space. A beat presented while `wr_ready` is low is not held: it is dropped, and `wr_ovf` pulses for one cycle. A host that never drives `wr_valid` while `wr_ready` is low never loses data. Configuration inputs are sampled when each character is loaded into the shifter, and should change only while `tx_empty` is high.

Top module: `ser_tx_path`

## Requirements
- R1: Each character is a 0 start bit, then data bits with bit 0 first, then the stop bits at 1. The data width is 5 + `cfg_wlen` (`cfg_wlen` 0..3 gives 5..8 bits). There is one stop bit when `cfg_stop2`=0 and two when it is 1. Every bit lasts exactly 16 `baud16_en` pulses.
- R2: When `cfg_par_en`=1, a parity bit follows the data bits. With `cfg_par_even`=1 the data bits plus the parity bit hold an even number of ones; with `cfg_par_even`=0 they hold an odd number.
- R3: `txd` is 1 out of reset and whenever `tx_empty` is high. `txd` changes only in a cycle that follows a `baud16_en` pulse.
- R4: With `cfg_fifo_en`=1, 32 bytes are accepted back to back while nothing drains, and every accepted byte is sent once, in the order written.
- R5: With `cfg_fifo_en`=0, the block holds one byte. `wr_ready` drops after one accepted write and rises again when that byte moves into the shifter.
- R6: A write presented while `wr_ready`=0 is discarded and never sent, and `wr_ovf` is 1 in the following cycle only.
- R7: `thr_empty` is 0 after an accepted write. It returns to 1 when the last waiting byte moves into the shifter: in single-register mode at the load itself, and in queued mode when the queue becomes empty.
- R8: `tx_empty` is 1 only when nothing is waiting and the shifter is idle. It stays 0 while a character is being shifted out.
- R9: In queued mode the interrupt becomes pending when a load takes the level from `cfg_trig` to `cfg_trig`-1, and also when a load takes the level from 1 to 0. In single-register mode every load sets it pending.
- R10: `tx_irq` is the pending flag gated by `cfg_irq_en`. The pending flag clears on an accepted write or on an `isr_rd` pulse. If a load that sets it falls in the same cycle, the load wins.
- R11: If another byte is waiting, its start bit begins on the `baud16_en` pulse that ends the previous stop bit. Start bits of back-to-back characters are therefore exactly 16 x (frame bits) pulses apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud16_en | input | 1 | One-cycle enable at 16x the baud rate |
| cfg_fifo_en | input | 1 | 1 = 32-entry queue, 0 = single holding register |
| cfg_wlen | input | 2 | Data width minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| cfg_irq_en | input | 1 | Transmit interrupt enable |
| cfg_trig | input | 6 | Queue trigger level (0..32) |
| wr_valid | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| wr_ready | output | 1 | Space available for a write |
| wr_ovf | output | 1 | One-cycle pulse after a discarded write |
| isr_rd | input | 1 | Interrupt-status read, clears pending |
| txd | output | 1 | Serial output, idle high |
| thr_empty | output | 1 | Nothing waiting to be sent |
| tx_empty | output | 1 | Nothing waiting and shifter idle |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The bench goes after the edges of storage and of the interrupt. It fills the queue to exactly 32 and writes once more; a capacity that is off by one would either drop the 32nd byte or accept the 33rd without an overflow pulse. It drains a queue past the trigger level and then to empty while reading the status in between. An interrupt that fires on the wrong level, or fires only once, shows up at a specific character. It also checks that the start bits of a preloaded burst are exactly one frame apart, so an added idle bit between characters is caught, and it uses random word length, parity and stop settings so that a misplaced parity bit or a wrong parity sense shows up in the decoded frames.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  localparam int FRAME_W = 12;
  localparam int NB_W    = 4;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       stop2;
  } frame_cfg_t;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [NB_W-1:0]    nbits;
  } frame_t;

  typedef enum logic {SH_IDLE, SH_RUN} sh_state_t;

  // Lay out one character LSB-first: start, data, optional parity, stop bits.
  function automatic frame_t build_frame(input logic [7:0] d, input frame_cfg_t c);
    frame_t     f;
    int         wl;
    int         pos;
    logic [7:0] dm;
    logic       p;
    wl     = 5 + int'(c.wlen);
    f.bits = '1;
    f.bits[0] = 1'b0;
    dm     = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < wl) begin
        f.bits[i+1] = d[i];
        dm[i]       = d[i];
      end
    end
    p   = c.par_even ? (^dm) : ~(^dm);
    pos = 1 + wl;
    if (c.par_en) begin
      f.bits[pos] = p;
      pos = pos + 1;
    end
    pos     = pos + (c.stop2 ? 2 : 1);
    f.nbits = NB_W'(pos);
    return f;
  endfunction

endpackage

// File: rtl/txq_buffer.sv
module txq_buffer #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          push,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic [CW-1:0] level,
  output logic          ovf_pulse
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cap;
  logic          pop_ok;

  assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);
  assign wr_ready = (level < cap);
  assign push     = wr_valid & wr_ready;
  assign empty    = (level == '0);
  assign pop_ok   = pop & ~empty;
  assign rd_data  = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      level     <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= wr_valid & ~wr_ready;
      if (push)   wptr <= nxt(wptr);
      if (pop_ok) rptr <= nxt(rptr);
      case ({push, pop_ok})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
  import ser_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       have_data,
  input  logic [7:0] data,
  input  frame_cfg_t cfg,
  output logic       pop,
  output logic       busy,
  output logic       txd
);

  sh_state_t          state;
  logic [3:0]         sub;
  logic [NB_W-1:0]    bitcnt;
  logic [NB_W-1:0]    nb;
  logic [FRAME_W-1:0] sr;
  logic               bit_end;
  logic               frame_end;
  frame_t             nf;

  assign busy      = (state == SH_RUN);
  assign bit_end   = busy & (sub == 4'd15);
  assign frame_end = bit_end & (bitcnt == nb - NB_W'(1));
  assign pop       = tick & have_data & (~busy | frame_end);
  assign nf        = build_frame(data, cfg);
  assign txd       = busy ? sr[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SH_IDLE;
      sub    <= '0;
      bitcnt <= '0;
      nb     <= '0;
      sr     <= '1;
    end else if (tick) begin
      if (pop) begin
        state  <= SH_RUN;
        sr     <= nf.bits;
        nb     <= nf.nbits;
        bitcnt <= '0;
        sub    <= '0;
      end else if (busy) begin
        sub <= sub + 4'd1;
        if (frame_end) begin
          state <= SH_IDLE;
          sr    <= '1;
        end else if (bit_end) begin
          sr     <= {1'b1, sr[FRAME_W-1:1]};
          bitcnt <= bitcnt + NB_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/txe_irq_ctrl.sv
module txe_irq_ctrl #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          load,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] trig,
  input  logic          host_wr,
  input  logic          isr_rd,
  input  logic          irq_en,
  output logic          irq
);

  logic pend;
  logic set_ev;
  logic crossing;
  logic drained;

  // level is the count before the load removes one entry
  assign crossing = (level == trig);
  assign drained  = (level == CW'(1));
  assign set_ev   = load & (fifo_en ? (crossing | drained) : 1'b1);
  assign irq      = pend & irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n)                pend <= 1'b0;
    else if (set_ev)           pend <= 1'b1;
    else if (host_wr | isr_rd) pend <= 1'b0;
  end

endmodule

// File: rtl/ser_tx_path.sv
module ser_tx_path
  import ser_tx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud16_en,
  input  logic          cfg_fifo_en,
  input  logic [1:0]    cfg_wlen,
  input  logic          cfg_par_en,
  input  logic          cfg_par_even,
  input  logic          cfg_stop2,
  input  logic          cfg_irq_en,
  input  logic [CW-1:0] cfg_trig,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  output logic          wr_ready,
  output logic          wr_ovf,
  input  logic          isr_rd,
  output logic          txd,
  output logic          thr_empty,
  output logic          tx_empty,
  output logic          tx_irq
);

  logic          push, pop, busy, q_empty;
  logic [7:0]    q_data;
  logic [CW-1:0] q_level;
  frame_cfg_t    fcfg;

  assign fcfg = '{wlen: cfg_wlen, par_en: cfg_par_en, par_even: cfg_par_even, stop2: cfg_stop2};

  txq_buffer #(.DEPTH(DEPTH), .DW(8)) u_q (
    .clk(clk), .rst_n(rst_n), .fifo_en(cfg_fifo_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready), .push(push),
    .pop(pop), .rd_data(q_data), .empty(q_empty), .level(q_level),
    .ovf_pulse(wr_ovf)
  );

  tx_serializer u_sh (
    .clk(clk), .rst_n(rst_n), .tick(baud16_en), .have_data(~q_empty),
    .data(q_data), .cfg(fcfg), .pop(pop), .busy(busy), .txd(txd)
  );

  txe_irq_ctrl #(.CW(CW)) u_irq (
    .clk(clk), .rst_n(rst_n), .fifo_en(cfg_fifo_en), .load(pop),
    .level(q_level), .trig(cfg_trig), .host_wr(push), .isr_rd(isr_rd),
    .irq_en(cfg_irq_en), .irq(tx_irq)
  );

  assign thr_empty = q_empty;
  assign tx_empty  = q_empty & ~busy;

endmodule

// File: rtl/ser_tx_path_chk.sv
module ser_tx_path_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          baud16_en,
  input logic          cfg_irq_en,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          wr_ovf,
  input logic          isr_rd,
  input logic          txd,
  input logic          thr_empty,
  input logic          tx_empty,
  input logic          tx_irq,
  input logic [CW-1:0] cfg_trig
);

  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

  assert_txd_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !baud16_en |=> $stable(txd));

  assert_reject_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_ovf);

  assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ovf |-> $past(wr_valid && !wr_ready));

  assert_write_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !thr_empty);

  assert_empty_nest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> thr_empty);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |-> !tx_irq);

  assert_isr_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !baud16_en) |=> !tx_irq);

endmodule

bind ser_tx_path ser_tx_path_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .baud16_en(baud16_en), .cfg_irq_en(cfg_irq_en),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_ovf(wr_ovf), .isr_rd(isr_rd),
  .txd(txd), .thr_empty(thr_empty), .tx_empty(tx_empty), .tx_irq(tx_irq),
  .cfg_trig(cfg_trig)
);

// File: tb/sim_ser_tx_path.sv
`timescale 1ns/1ps
module sim_ser_tx_path;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud16_en;
  logic       baud_on = 1'b0;
  logic       ph;
  logic       cfg_fifo_en = 1'b0;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_stop2 = 1'b0;
  logic       cfg_irq_en = 1'b1;
  logic [5:0] cfg_trig = 6'd4;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       isr_rd = 1'b0;
  logic       wr_ready, wr_ovf, txd, thr_empty, tx_empty, tx_irq;

  always #5 clk = ~clk;

  ser_tx_path u0 (
    .clk(clk), .rst_n(rst_n), .baud16_en(baud16_en), .cfg_fifo_en(cfg_fifo_en),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_stop2(cfg_stop2), .cfg_irq_en(cfg_irq_en), .cfg_trig(cfg_trig),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready), .wr_ovf(wr_ovf),
    .isr_rd(isr_rd), .txd(txd), .thr_empty(thr_empty), .tx_empty(tx_empty),
    .tx_irq(tx_irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int tick_no;

  always @(posedge clk) begin
    if (!rst_n) begin ph <= 1'b0; baud16_en <= 1'b0; tick_no <= 0; end
    else begin
      ph <= ~ph;
      baud16_en <= baud_on & ph;
      if (baud16_en) tick_no <= tick_no + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int frame_bits();
    return 1 + 5 + int'(cfg_wlen) + (cfg_par_en ? 1 : 0) + (cfg_stop2 ? 2 : 1);
  endfunction

  // ---------------- line monitor ----------------
  logic [7:0] exp_q[$];
  bit   hunting = 1;
  int   st_tick, bidx, nb_cur, starts = 0, frames = 0;
  logic [11:0] rbits;
  int   start_at [0:511];
  bit   irq_at   [0:511];
  bit   thre_at  [0:511];
  bit   txe_at   [0:511];

  task automatic finish_frame();
    int wl; int d; int expd; int ones; int pos;
    wl = 5 + int'(cfg_wlen);
    d = 0;
    for (int i = 0; i < wl; i++) d = d | (int'(rbits[i+1]) << i);
    chk(rbits[0] == 1'b0, "R1", "start bit", int'(rbits[0]), 0);
    if (exp_q.size() == 0) begin
      chk(0, "R6", "unexpected character", d, -1);
    end else begin
      expd = int'(exp_q.pop_front()) & ((1 << wl) - 1);
      chk(d == expd, "R1", "data bits", d, expd);
    end
    pos = 1 + wl;
    if (cfg_par_en) begin
      ones = $countones(d) + int'(rbits[pos]);
      chk((ones % 2) == (cfg_par_even ? 0 : 1), "R2", "parity ones", ones % 2, cfg_par_even ? 0 : 1);
      pos++;
    end
    chk(rbits[pos] == 1'b1, "R1", "stop bit 1", int'(rbits[pos]), 1);
    if (cfg_stop2) chk(rbits[pos+1] == 1'b1, "R1", "stop bit 2", int'(rbits[pos+1]), 1);
  endtask

  always @(negedge clk) begin
    if (!rst_n) hunting = 1;
    else if (hunting) begin
      if (txd == 1'b0) begin
        hunting = 0; st_tick = tick_no; bidx = 0; nb_cur = frame_bits();
        start_at[starts] = tick_no; irq_at[starts] = tx_irq;
        thre_at[starts] = thr_empty; txe_at[starts] = tx_empty;
        starts++;
      end
    end else if (tick_no == st_tick + 16*bidx + 8) begin
      rbits[bidx] = txd;
      bidx++;
      if (bidx == nb_cur) begin finish_frame(); hunting = 1; frames++; end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_byte(input logic [7:0] d, output bit acc, output bit ovf);
    @(negedge clk);
    acc = wr_ready; wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    ovf = wr_ovf;
    if (acc) exp_q.push_back(d);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(tx_empty && hunting));
  endtask

  // ---------------- main sequence ----------------
  initial begin
    bit acc, ovf;
    int b;
    void'($urandom(32'd1337));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R3", "txd after reset", int'(txd), 1);
    chk(thr_empty == 1'b1, "R7", "thr_empty after reset", int'(thr_empty), 1);
    chk(tx_empty == 1'b1, "R8", "tx_empty after reset", int'(tx_empty), 1);
    chk(tx_irq == 1'b0, "R10", "irq after reset", int'(tx_irq), 0);
    chk(wr_ready == 1'b1, "R5", "ready after reset", int'(wr_ready), 1);

    // single-register mode
    b = starts;
    wr_byte(8'hA5, acc, ovf);
    chk(acc, "R5", "first write accepted", int'(acc), 1);
    chk(wr_ready == 1'b0, "R5", "ready low when holding full", int'(wr_ready), 0);
    chk(thr_empty == 1'b0, "R7", "thr_empty after write", int'(thr_empty), 0);
    chk(tx_empty == 1'b0, "R8", "tx_empty with byte waiting", int'(tx_empty), 0);
    wr_byte(8'h3C, acc, ovf);
    chk(!acc, "R6", "second write refused", int'(acc), 0);
    chk(ovf, "R6", "overflow pulse", int'(ovf), 1);
    @(negedge clk);
    chk(wr_ovf == 1'b0, "R6", "overflow pulse one cycle", int'(wr_ovf), 0);
    baud_on = 1'b1;
    wait (starts == b + 1);
    @(negedge clk);
    chk(thre_at[b] == 1'b1, "R7", "holding empty at load", int'(thre_at[b]), 1);
    chk(txe_at[b] == 1'b0, "R8", "tx_empty low while shifting", int'(txe_at[b]), 0);
    chk(irq_at[b] == 1'b1, "R9", "single-mode irq at load", int'(irq_at[b]), 1);
    chk(wr_ready == 1'b1, "R5", "ready back after load", int'(wr_ready), 1);
    wait_idle();
    chk(exp_q.size() == 0, "R6", "refused byte never sent", exp_q.size(), 0);
    isr_rd = 1'b1; @(negedge clk); isr_rd = 1'b0;
    chk(tx_irq == 1'b0, "R10", "isr read clears", int'(tx_irq), 0);

    // queue full and drain with trigger crossing
    baud_on = 1'b0; cfg_fifo_en = 1'b1; cfg_trig = 6'd4;
    repeat (4) @(negedge clk);
    b = starts;
    for (int i = 0; i < 32; i++) begin
      wr_byte(8'(i * 7 + 3), acc, ovf);
      chk(acc, "R4", "queue write accepted", i, 1);
    end
    wr_byte(8'hEE, acc, ovf);
    chk(!acc && ovf, "R6", "33rd write overflow", int'(ovf), 1);
    baud_on = 1'b1;
    wait_idle();
    chk(starts - b == 32, "R4", "characters sent", starts - b, 32);
    chk(exp_q.size() == 0, "R4", "all queued bytes sent", exp_q.size(), 0);
    chk(irq_at[b+27] == 1'b0, "R9", "no irq above trigger", int'(irq_at[b+27]), 0);
    chk(irq_at[b+28] == 1'b1, "R9", "irq when level drops below trigger", int'(irq_at[b+28]), 1);

    // re-fire on empty after a status read
    baud_on = 1'b0; repeat (4) @(negedge clk);
    b = starts;
    for (int i = 0; i < 6; i++) wr_byte(8'(8'h40 + i), acc, ovf);
    chk(tx_irq == 1'b0, "R10", "writes clear pending", int'(tx_irq), 0);
    baud_on = 1'b1;
    wait (starts == b + 3);
    @(negedge clk); isr_rd = 1'b1; @(negedge clk); isr_rd = 1'b0;
    chk(tx_irq == 1'b0, "R10", "isr read clears mid-drain", int'(tx_irq), 0);
    wait_idle();
    chk(irq_at[b+1] == 1'b0, "R9", "no irq at level 5->4", int'(irq_at[b+1]), 0);
    chk(irq_at[b+2] == 1'b1, "R9", "irq at level 4->3", int'(irq_at[b+2]), 1);
    chk(irq_at[b+4] == 1'b0, "R9", "stays clear 2->1", int'(irq_at[b+4]), 0);
    chk(irq_at[b+5] == 1'b1, "R9", "irq again at empty", int'(irq_at[b+5]), 1);
    chk(thre_at[b+4] == 1'b0, "R7", "queue not empty at 2->1", int'(thre_at[b+4]), 0);
    chk(thre_at[b+5] == 1'b1, "R7", "queue empty at last load", int'(thre_at[b+5]), 1);
    cfg_irq_en = 1'b0; @(negedge clk);
    chk(tx_irq == 1'b0, "R10", "irq gated off", int'(tx_irq), 0);
    cfg_irq_en = 1'b1; @(negedge clk);
    chk(tx_irq == 1'b1, "R10", "pending kept while gated", int'(tx_irq), 1);

    // back-to-back spacing, 7 bits even parity 2 stops
    baud_on = 1'b0; cfg_wlen = 2'd2; cfg_par_en = 1'b1; cfg_par_even = 1'b1; cfg_stop2 = 1'b1;
    repeat (4) @(negedge clk);
    b = starts;
    for (int i = 0; i < 4; i++) wr_byte(8'(8'h5A ^ (i * 8'h11)), acc, ovf);
    baud_on = 1'b1;
    wait_idle();
    for (int i = 1; i < 4; i++)
      chk(start_at[b+i] - start_at[b+i-1] == 16 * frame_bits(), "R11", "start spacing",
          start_at[b+i] - start_at[b+i-1], 16 * frame_bits());

    // random configurations and traffic
    for (int c = 0; c < 6; c++) begin
      wait_idle();
      cfg_wlen = 2'($urandom_range(0, 3));
      cfg_par_en = 1'($urandom_range(0, 1));
      cfg_par_even = 1'($urandom_range(0, 1));
      cfg_stop2 = 1'($urandom_range(0, 1));
      cfg_fifo_en = 1'($urandom_range(0, 1));
      for (int k = 0; k < 20; k++) begin
        wr_byte(8'($urandom_range(0, 255)), acc, ovf);
        chk(ovf == !acc, "R6", "overflow matches refusal", int'(ovf), int'(!acc));
        repeat ($urandom_range(0, 60)) @(negedge clk);
      end
      wait_idle();
      chk(exp_q.size() == 0, "R4", "random batch drained", exp_q.size(), 0);
      chk(txd == 1'b1, "R3", "idle line high", int'(txd), 1);
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule